// File: doc/BRIEF.md
# Timer input capture unit

This block records the value of a free-running timer at the moment a qualifying transition appears on an external capture pin. The pin passes through a clock-domain synchronizer and an edge detector. A mode field then selects two things together: which edge counts, and whether every edge, every 4th edge or every 16th edge causes a capture. On a capture, the 16-bit value of one of two timers, chosen by a select input, is loaded into a holding register, and an interrupt request flag is raised.

The flag stays set until software pulses a clear strobe. If a capture and a clear arrive in the same cycle, the capture wins. A later capture always replaces the held value, whether or not the earlier value was read. Turning the unit off, or writing an unused mode code, empties the event prescaler. Moving directly from one capture mode to another leaves the prescaler count as it was. Software that needs a clean count therefore passes through the off code first.

Top module: `timer_capture`

## Requirements
- R1: Mode codes on `mode_i`: 4'b0100 captures on every falling edge, 4'b0101 on every rising edge, 4'b0110 on every 4th rising edge and 4'b0111 on every 16th rising edge. 4'b0000 and all other codes disable capture.
- R2: A capture loads `timer_a_i` when `timer_sel_i` is 0 and `timer_b_i` when it is 1. The sampled value is the one present in the cycle before the load.
- R3: After a pin transition, the capture register and flag change on the third rising clock edge. Two edges go to the synchronizer and one to the load.
- R4: In falling-edge mode, rising edges cause no capture. In the rising-edge modes, falling edges cause no capture.
- R5: In the divide-by-4 mode, starting from an empty prescaler, the 4th, 8th and later multiples of 4 rising edges capture, and no other edge does.
- R6: In the divide-by-16 mode, starting from an empty prescaler, only the 16th rising edge of each group of 16 captures.
- R7: Each capture sets `irq_flag_o`. The flag then holds until a cycle with `flag_clr_i` high and no capture, after which it reads 0.
- R8: A capture in the same cycle as `flag_clr_i` leaves `irq_flag_o` set.
- R9: Every capture overwrites `cap_val_o`, even while the flag is still set. Without a capture, the register keeps its value.
- R10: In the off state or with an unused code, no capture occurs, and the prescaler count returns to zero.
- R11: A direct switch between capture modes keeps the prescaler count. A divided mode captures at the first rising edge where the count has already reached its ratio minus one, and clears the count at that point.
- R12: After reset, `cap_val_o` is 0, `irq_flag_o` is 0 and the prescaler is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cap_pin_i | input | 1 | Capture pin, asynchronous to the clock |
| timer_a_i | input | 16 | Timer source 0 |
| timer_b_i | input | 16 | Timer source 1 |
| timer_sel_i | input | 1 | Source select: 0 chooses timer_a_i, 1 chooses timer_b_i |
| mode_i | input | 4 | Edge polarity and prescale code |
| flag_clr_i | input | 1 | Software clear strobe for the flag |
| cap_val_o | output | 16 | Captured timer value |
| irq_flag_o | output | 1 | Capture interrupt request flag |

## Verification
Each mode is driven with trains of full pin pulses. The timer values change between pulses, so the captured value shows exactly which edge triggered the capture and which timer source was used. This separates polarity errors from prescale-ratio errors and select errors. The mode-change sequences compare a switch from divide-by-16 to divide-by-4 made directly with the same switch made through the off code. A carried-over count captures on the first edge, while a cleared count waits for the fourth. Cycle-exact directed pulses pin down the three-edge latency and the race between a capture and a flag clear.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef struct packed {
    logic       active;
    logic       on_fall;
    logic [1:0] div_sel;  // 0: /1, 1: /4, 2: /16
  } cap_mode_t;

  function automatic cap_mode_t decode_mode(input logic [3:0] code);
    cap_mode_t m;
    m = '0;
    case (code)
      4'b0100: begin m.active = 1'b1; m.on_fall = 1'b1; end
      4'b0101: begin m.active = 1'b1; end
      4'b0110: begin m.active = 1'b1; m.div_sel = 2'd1; end
      4'b0111: begin m.active = 1'b1; m.div_sel = 2'd2; end
      default: m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/cap_edge_sync.sv
module cap_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] sync_q;
  logic         prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[N-2:0], pin_i};
      prev_q <= sync_q[N-1];
    end
  end

  assign rise_o = sync_q[N-1] & ~prev_q;
  assign fall_o = ~sync_q[N-1] & prev_q;
endmodule

// File: rtl/cap_prescaler.sv
module cap_prescaler #(
  parameter int PS_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            active_i,
  input  logic            evt_i,
  input  logic [PS_W-1:0] ratio_m1_i,
  output logic            fire_o
);
  logic [PS_W-1:0] cnt_q;
  logic            reached;

  // >= so a count carried over from a larger ratio fires at once
  assign reached = (ratio_m1_i == '0) || (cnt_q >= ratio_m1_i);
  assign fire_o  = active_i && evt_i && reached;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             cnt_q <= '0;
    else if (!active_i)                      cnt_q <= '0;
    else if (evt_i && ratio_m1_i != '0) begin
      if (reached) cnt_q <= '0;
      else         cnt_q <= cnt_q + 1'b1;
    end
  end

  p_off_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> cnt_q == '0);
  p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i && !evt_i |=> $stable(cnt_q));
endmodule

// File: rtl/timer_capture.sv
module timer_capture #(
  parameter int TIMER_W     = 16,
  parameter int SYNC_STAGES = 2,
  parameter int PS_W        = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cap_pin_i,
  input  logic [TIMER_W-1:0] timer_a_i,
  input  logic [TIMER_W-1:0] timer_b_i,
  input  logic               timer_sel_i,
  input  logic [3:0]         mode_i,
  input  logic               flag_clr_i,
  output logic [TIMER_W-1:0] cap_val_o,
  output logic               irq_flag_o
);
  import cap_pkg::*;

  localparam logic [PS_W-1:0] RATIO4_M1  = PS_W'(3);
  localparam logic [PS_W-1:0] RATIO16_M1 = PS_W'(15);

  cap_mode_t       mode;
  logic            rise, fall, evt, fire;
  logic [PS_W-1:0] ratio_m1;

  assign mode = decode_mode(mode_i);

  always_comb begin
    case (mode.div_sel)
      2'd1:    ratio_m1 = RATIO4_M1;
      2'd2:    ratio_m1 = RATIO16_M1;
      default: ratio_m1 = '0;
    endcase
  end

  cap_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (cap_pin_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign evt = mode.on_fall ? fall : rise;

  cap_prescaler #(.PS_W(PS_W)) u_ps (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (mode.active),
    .evt_i      (evt),
    .ratio_m1_i (ratio_m1),
    .fire_o     (fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_val_o  <= '0;
      irq_flag_o <= 1'b0;
    end else begin
      if (fire) cap_val_o <= timer_sel_i ? timer_b_i : timer_a_i;
      // capture beats a simultaneous clear
      if (fire)            irq_flag_o <= 1'b1;
      else if (flag_clr_i) irq_flag_o <= 1'b0;
    end
  end

  p_fire_needs_edge_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |-> (rise || fall));
  p_no_cap_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode.active |-> !fire);
  p_flag_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> irq_flag_o);
  p_flag_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire && flag_clr_i |=> !irq_flag_o);
  p_flag_race_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && flag_clr_i |=> irq_flag_o);
  p_cap_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire |=> $stable(cap_val_o));
  p_cap_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && !timer_sel_i |=> cap_val_o == $past(timer_a_i));
endmodule

// File: tb/timer_capture_bench.sv
`timescale 1ns/1ps
module timer_capture_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin = 1'b0;
  logic [15:0] ta = '0, tb = '0;
  logic        sel = 1'b0;
  logic [3:0]  mode = 4'b0000;
  logic        clr = 1'b0;
  logic [15:0] cap;
  logic        flag;

  int total = 0, bad = 0;
  int m_cnt = 0, pcount = 0;
  logic [15:0] m_cap = '0;
  logic        m_flag = 1'b0;

  always #2 clk = ~clk;

  timer_capture u_timer_capture (
    .clk_i(clk), .rst_ni(rst_n), .cap_pin_i(pin),
    .timer_a_i(ta), .timer_b_i(tb), .timer_sel_i(sel),
    .mode_i(mode), .flag_clr_i(clr),
    .cap_val_o(cap), .irq_flag_o(flag)
  );

  // fields: mode[9:6] sel[5] pulses[4:0]
  localparam int NV = 8;
  localparam logic [9:0] VEC [NV] = '{
    {4'b0101, 1'b0, 5'd3},
    {4'b0100, 1'b1, 5'd3},
    {4'b0110, 1'b0, 5'd9},
    {4'b0111, 1'b1, 5'd17},
    {4'b0000, 1'b0, 5'd3},
    {4'b1010, 1'b0, 5'd3},
    {4'b0011, 1'b1, 5'd2},
    {4'b0101, 1'b1, 5'd2}
  };

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit m_active(input logic [3:0] m);
    return m inside {4'b0100, 4'b0101, 4'b0110, 4'b0111};
  endfunction

  // reference model of one pin transition
  task automatic model_edge(input bit is_rise);
    bit ev, fire;
    int ratio;
    fire = 0;
    ev = m_active(mode) && ((mode == 4'b0100) ? !is_rise : is_rise);
    if (ev) begin
      ratio = (mode == 4'b0110) ? 4 : (mode == 4'b0111) ? 16 : 1;
      if (ratio == 1) fire = 1;
      else if (m_cnt >= ratio - 1) begin fire = 1; m_cnt = 0; end
      else m_cnt++;
    end
    if (fire) begin
      m_cap  = sel ? tb : ta;
      m_flag = 1'b1;
    end
  endtask

  task automatic set_mode(input logic [3:0] m);
    @(negedge clk);
    mode = m;
    if (!m_active(m)) m_cnt = 0;
    @(negedge clk);
  endtask

  task automatic clear_flag();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    m_flag = 1'b0;
  endtask

  task automatic half(input bit lvl, input string req);
    @(negedge clk);
    pin = lvl;
    model_edge(lvl);
    repeat (4) @(negedge clk);
    chk({req, " cap"}, 32'(cap), 32'(m_cap));
    chk({req, " flag"}, 32'(flag), 32'(m_flag));
  endtask

  task automatic pulse(input string req);
    @(negedge clk);
    pcount++;
    ta = 16'h1000 + 16'(pcount * 7);
    tb = 16'hA000 ^ 16'(pcount * 13);
    half(1'b1, req);
    half(1'b0, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 cap reset", 32'(cap), 32'h0);
    chk("R12 flag reset", 32'(flag), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      set_mode(4'b0000);
      clear_flag();
      sel = VEC[v][5];
      set_mode(VEC[v][9:6]);
      for (int p = 0; p < int'(VEC[v][4:0]); p++)
        pulse("R1 R2 R4 R5 R6 R9 R10 vector");
    end

    // R3: latency, pin high then count edges
    set_mode(4'b0000); clear_flag(); set_mode(4'b0101);
    ta = 16'h3C3C; sel = 1'b0;
    @(negedge clk); pin = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R3 flag before 3rd edge", 32'(flag), 32'h0);
    @(negedge clk);
    chk("R3 flag at 3rd edge", 32'(flag), 32'h1);
    chk("R3 cap at 3rd edge", 32'(cap), 32'h3C3C);
    m_cap = 16'h3C3C; m_flag = 1'b1;
    @(negedge clk); pin = 1'b0;
    repeat (4) @(negedge clk);

    // R7: clear with no capture, then hold
    clear_flag();
    chk("R7 flag cleared", 32'(flag), 32'h0);
    pulse("R7 flag set");
    repeat (3) @(negedge clk);
    chk("R7 flag held", 32'(flag), 32'h1);

    // R8: clear lands in the capture cycle
    clear_flag();
    ta = 16'h7E57;
    @(negedge clk); pin = 1'b1;
    @(negedge clk); @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    chk("R8 capture beats clear", 32'(flag), 32'h1);
    chk("R8 cap", 32'(cap), 32'h7E57);
    m_cap = 16'h7E57; m_flag = 1'b1;
    @(negedge clk); pin = 1'b0;
    repeat (4) @(negedge clk);

    // R11: direct switch /16 -> /4 keeps count of 10
    set_mode(4'b0000); clear_flag(); set_mode(4'b0111);
    for (int i = 0; i < 10; i++) pulse("R11 prefill");
    set_mode(4'b0110);
    pulse("R11 direct switch");
    chk("R11 early capture", 32'(flag), 32'h1);

    // R10: switch via off clears count, needs 4 edges
    set_mode(4'b0111);
    for (int i = 0; i < 10; i++) pulse("R10 prefill");
    set_mode(4'b0000); clear_flag(); set_mode(4'b0110);
    for (int i = 0; i < 3; i++) pulse("R10 cleared count");
    chk("R10 no early capture", 32'(flag), 32'h0);
    pulse("R10 fourth edge");
    chk("R10 fourth captures", 32'(flag), 32'h1);

    summary();
    $finish;
  end
endmodule